// File: doc/BRIEF.md
# Switchable-Oversampling Baud Tick Generator

This block turns the system clock into the timing strobes of an asynchronous serial port. A 12-bit reload value sets how many system clocks separate two receiver sample ticks. A second counter groups those sample ticks into bit periods: 16 ticks per bit normally, or 8 when the fast-rate control is on. The fast rate therefore doubles the bit rate for the same reload value, and the receiver gets half as many samples for each bit.

The fast-rate control works only in asynchronous operation. When the port is set to synchronous mode, the control is treated as zero and the 16-tick grouping applies. Alongside the two strobes, the block outputs the position of the current sample within its bit and a vote strobe that marks the three central samples. A receiver uses these to take its majority vote. Loading a new reload value restarts the divider at once. While the port is disabled, both counters are held.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low (sampled on a clock edge) or `port_en` is low, `sample_tick`, `bit_tick` and `vote_tick` stay 0 and `sample_idx` reads 0.
- R2: With reload value R (0 to 4095) and the port enabled, `sample_tick` is a one-cycle pulse every R+1 clocks. R=0 gives a pulse on every clock.
- R3: With `dbl_speed`=0, `sample_idx` counts 0 to 15, one step per sample tick. `bit_tick` pulses together with the sample tick at index 15, so one bit lasts 16*(R+1) clocks.
- R4: With `dbl_speed`=1 and `sync_mode`=0, `sample_idx` counts 0 to 7. `bit_tick` pulses with the sample tick at index 7, so one bit lasts 8*(R+1) clocks.
- R5: With `sync_mode`=1, `dbl_speed` has no effect and the 16-tick grouping of R3 applies.
- R6: `vote_tick` pulses together with the sample ticks at index 7, 8 and 9 in 16-tick mode, and at index 3, 4 and 5 in 8-tick mode. That gives exactly three vote ticks per bit, and none of them falls on a `bit_tick`.
- R7: No `sample_tick` occurs in a cycle where `reload_wr` is high. The value on `reload_val` is loaded, and if `reload_wr` is held for one clock, the first sample tick comes in the (R+1)th cycle after the write cycle, with R the new value.
- R8: When `port_en` rises after R has been presented while the port was disabled, the first sample tick has index 0 and arrives R cycles after the enabling cycle. The first `bit_tick` follows (ratio-1)*(R+1) cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable; low holds both counters |
| sync_mode | input | 1 | 1 = synchronous operation; forces the fast rate off |
| dbl_speed | input | 1 | 1 = 8 sample ticks per bit (asynchronous only) |
| reload_val | input | 12 | Divider reload value R |
| reload_wr | input | 1 | Load strobe for `reload_val`; restarts the divider |
| sample_tick | output | 1 | Receiver sample-rate enable pulse |
| bit_tick | output | 1 | Bit-rate enable pulse |
| sample_idx | output | 4 | Position of the current sample within the bit |
| vote_tick | output | 1 | Marks the three central samples of a bit |

## Verification
A table of settings crosses reload values 0, 1, 3 and 5 with the fast-rate control on and off, in both asynchronous and synchronous mode. Each run measures the gap between sample ticks, the bit length in clocks, the sample count per bit and where the vote ticks fall. Reload 0 separates a divider that ticks every clock from one that skips a cycle. Pairing the fast-rate control with synchronous mode separates correct forcing from a gate that ignores the mode. Directed tests then time the first tick after a reload write mid-period and after enabling the port, which catches an off-by-one in the reload or a counter not cleared.

// File: rtl/baud_pkg.sv
// Shared widths and the per-mode sampling configuration for the baud tick
// generator. Assumes both oversampling ratios are powers of two no larger
// than 2**BAUD_IDX_W.
package baud_pkg;

    localparam int BAUD_RELOAD_W = 12;
    localparam int BAUD_OSR_NORM = 16;
    localparam int BAUD_OSR_FAST = 8;
    localparam int BAUD_IDX_W    = $clog2(BAUD_OSR_NORM);

    // Per-mode sample-counter limits: wrap index and vote window bounds
    typedef struct packed {
        logic [BAUD_IDX_W-1:0] last_idx;
        logic [BAUD_IDX_W-1:0] vote_lo;
        logic [BAUD_IDX_W-1:0] vote_hi;
    } osr_cfg_t;

endpackage

// File: rtl/baud_divider.sv
// Reload divider: counts down from the reload value to zero and issues one
// sample tick at zero, then reloads. A reload of R gives a tick every R+1
// clocks. Assumes load and enable are synchronous to clk.
module baud_divider #(
    parameter int RELOAD_W = baud_pkg::BAUD_RELOAD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                load,
    input  logic [RELOAD_W-1:0] reload_val,
    output logic                tick
);

    localparam logic [RELOAD_W-1:0] CNT_ZERO = '0;
    localparam logic [RELOAD_W-1:0] CNT_ONE  = RELOAD_W'(1);

    logic [RELOAD_W-1:0] cnt_q;
    logic                at_zero;

    assign at_zero = (cnt_q == CNT_ZERO);

    // Down-counter: preload while off or written, reload on reaching zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else if (!enable || load) begin
            cnt_q <= reload_val;
        end else if (at_zero) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // Tick only on an enabled, non-write cycle with the count at zero
    always_comb begin
        tick = enable && !load && at_zero;
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(enable) && enable && !$past(load) && !$past(at_zero)
        |-> cnt_q == $past(cnt_q) - CNT_ONE);

    // R7
    load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load) |-> cnt_q == $past(reload_val));

endmodule

// File: rtl/baud_mode_sel.sv
// Mode gating: derives the effective fast-rate setting (forced off in
// synchronous mode) and the matching sample-counter limits. Purely
// combinational; assumes the two ratios are even and at least 4.
module baud_mode_sel #(
    parameter int OSR_NORM = baud_pkg::BAUD_OSR_NORM,
    parameter int OSR_FAST = baud_pkg::BAUD_OSR_FAST,
    parameter int IDX_W    = baud_pkg::BAUD_IDX_W
) (
    input  logic                dbl_req,
    input  logic                sync_mode,
    output logic                dbl_eff,
    output baud_pkg::osr_cfg_t  cfg
);

    localparam logic [IDX_W-1:0] NORM_LAST = IDX_W'(OSR_NORM - 1);
    localparam logic [IDX_W-1:0] FAST_LAST = IDX_W'(OSR_FAST - 1);
    localparam logic [IDX_W-1:0] NORM_VLO  = IDX_W'(OSR_NORM / 2 - 1);
    localparam logic [IDX_W-1:0] NORM_VHI  = IDX_W'(OSR_NORM / 2 + 1);
    localparam logic [IDX_W-1:0] FAST_VLO  = IDX_W'(OSR_FAST / 2 - 1);
    localparam logic [IDX_W-1:0] FAST_VHI  = IDX_W'(OSR_FAST / 2 + 1);

    // Fast rate applies only in asynchronous operation
    always_comb begin
        dbl_eff = dbl_req && !sync_mode;
    end

    // Select wrap point and vote window for the active ratio
    always_comb begin
        if (dbl_eff) begin
            cfg.last_idx = FAST_LAST;
            cfg.vote_lo  = FAST_VLO;
            cfg.vote_hi  = FAST_VHI;
        end else begin
            cfg.last_idx = NORM_LAST;
            cfg.vote_lo  = NORM_VLO;
            cfg.vote_hi  = NORM_VHI;
        end
    end

endmodule

// File: rtl/baud_oversample.sv
// Oversampling counter: counts sample ticks within a bit, wraps at the
// configured last index and marks the bit boundary and the vote window.
// Assumes tick is a one-cycle strobe from the divider.
module baud_oversample #(
    parameter int IDX_W = baud_pkg::BAUD_IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               tick,
    input  baud_pkg::osr_cfg_t cfg,
    output logic [IDX_W-1:0]   idx,
    output logic               bit_tick,
    output logic               vote_tick
);

    localparam logic [IDX_W-1:0] IDX_ZERO = '0;
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    logic [IDX_W-1:0] idx_q;
    logic             at_last;

    // A switch to the short ratio mid-bit also wraps an index past the end
    assign at_last = (idx_q >= cfg.last_idx);

    // Sample index: held at zero while off, steps on each sample tick
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            idx_q <= IDX_ZERO;
        end else if (tick) begin
            idx_q <= at_last ? IDX_ZERO : idx_q + IDX_ONE;
        end
    end

    // Bit boundary and central-sample strobes
    always_comb begin
        bit_tick  = tick && at_last;
        vote_tick = tick && (idx_q >= cfg.vote_lo) && (idx_q <= cfg.vote_hi);
    end

    assign idx = idx_q;

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(enable) && enable && $past(tick) && !$past(bit_tick)
        |-> idx_q == $past(idx_q) + IDX_ONE);

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(enable) && enable && !$past(tick)
        |-> $stable(idx_q));

endmodule

// File: rtl/baud_tick_gen.sv
// Top level: reload divider feeding an oversampling counter, with the
// fast-rate control gated by the synchronous-mode select. Assumes all
// inputs are synchronous to clk; reset is synchronous and active low.
module baud_tick_gen #(
    parameter int RELOAD_W = baud_pkg::BAUD_RELOAD_W,
    parameter int OSR_NORM = baud_pkg::BAUD_OSR_NORM,
    parameter int OSR_FAST = baud_pkg::BAUD_OSR_FAST,
    parameter int IDX_W    = baud_pkg::BAUD_IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                port_en,
    input  logic                sync_mode,
    input  logic                dbl_speed,
    input  logic [RELOAD_W-1:0] reload_val,
    input  logic                reload_wr,
    output logic                sample_tick,
    output logic                bit_tick,
    output logic [IDX_W-1:0]    sample_idx,
    output logic                vote_tick
);

    localparam logic [IDX_W-1:0] NORM_LAST = IDX_W'(OSR_NORM - 1);
    localparam logic [IDX_W-1:0] FAST_LAST = IDX_W'(OSR_FAST - 1);

    logic               run;
    logic               div_tick;
    logic               dbl_eff;
    baud_pkg::osr_cfg_t osr_cfg;

    // Counters run only out of reset with the port enabled
    always_comb begin
        run = rst_n && port_en;
    end

    baud_divider #(
        .RELOAD_W (RELOAD_W)
    ) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (run),
        .load       (reload_wr),
        .reload_val (reload_val),
        .tick       (div_tick)
    );

    baud_mode_sel #(
        .OSR_NORM (OSR_NORM),
        .OSR_FAST (OSR_FAST),
        .IDX_W    (IDX_W)
    ) mode_i (
        .dbl_req   (dbl_speed),
        .sync_mode (sync_mode),
        .dbl_eff   (dbl_eff),
        .cfg       (osr_cfg)
    );

    baud_oversample #(
        .IDX_W (IDX_W)
    ) ovs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (run),
        .tick      (div_tick),
        .cfg       (osr_cfg),
        .idx       (sample_idx),
        .bit_tick  (bit_tick),
        .vote_tick (vote_tick)
    );

    assign sample_tick = div_tick;

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !sample_tick && !bit_tick && !vote_tick);

    // R1
    off_idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> sample_idx == '0);

    // R4
    fast_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && dbl_speed && !sync_mode && $stable(dbl_speed) && $stable(sync_mode)
        && $past(rst_n) && !dbl_eff == 1'b0 |-> sample_idx == FAST_LAST);

    // R5
    sync_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && sync_mode && $stable(sync_mode) && $stable(dbl_speed) && $past(rst_n)
        && sample_idx <= NORM_LAST |-> sample_idx == NORM_LAST);

    // R6
    vote_not_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vote_tick |-> sample_tick && !bit_tick);

    // R7
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |-> !sample_tick);

endmodule

// File: tb/baud_tick_gen_tb_top.sv
// Self-checking bench: a table of reload/mode settings walked by one loop,
// then directed tests for reset, disable, reload restart and enable timing.
module baud_tick_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic        sync_mode = 1'b0;
    logic        dbl_speed = 1'b0;
    logic [11:0] reload_val = '0;
    logic        reload_wr = 1'b0;
    logic        sample_tick;
    logic        bit_tick;
    logic [3:0]  sample_idx;
    logic        vote_tick;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    baud_tick_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_en     (port_en),
        .sync_mode   (sync_mode),
        .dbl_speed   (dbl_speed),
        .reload_val  (reload_val),
        .reload_wr   (reload_wr),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick),
        .sample_idx  (sample_idx),
        .vote_tick   (vote_tick)
    );

    // {reload[11:0], dbl_speed, sync_mode}
    localparam int NVEC = 8;
    localparam logic [13:0] VEC [NVEC] = '{
        {12'd0, 1'b0, 1'b0},
        {12'd0, 1'b1, 1'b0},
        {12'd3, 1'b0, 1'b0},
        {12'd3, 1'b1, 1'b0},
        {12'd3, 1'b1, 1'b1},
        {12'd5, 1'b0, 1'b1},
        {12'd1, 1'b1, 1'b0},
        {12'd0, 1'b1, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_reload(input logic [11:0] r);
        @(negedge clk);
        reload_val = r;
        reload_wr  = 1'b1;
        @(negedge clk);
        reload_wr  = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // ---- R1: reset state ----
        repeat (4) @(negedge clk);
        port_en = 1'b1;
        @(negedge clk);
        chk(!sample_tick && !bit_tick && !vote_tick, "R1", "strobes in reset", sample_tick, 0);
        chk(sample_idx == 4'd0, "R1", "index in reset", sample_idx, 0);
        rst_n = 1'b1;

        // ---- table walk: R2..R6 ----
        for (int v = 0; v < NVEC; v++) begin
            int r, ratio, cyc, last_s, gap_bad, samples, votes, vote_bad, waitc;
            string req;
            r         = int'(VEC[v][13:2]);
            dbl_speed = VEC[v][1];
            sync_mode = VEC[v][0];
            ratio     = (VEC[v][1] && !VEC[v][0]) ? 8 : 16;
            req       = VEC[v][0] ? "R5" : (VEC[v][1] ? "R4" : "R3");
            write_reload(VEC[v][13:2]);
            waitc = 0;
            while (!bit_tick && waitc < 600) begin
                @(negedge clk);
                waitc++;
            end
            cyc = 0; last_s = 0; gap_bad = 0; samples = 0; votes = 0; vote_bad = 0;
            do begin
                @(negedge clk);
                cyc++;
                if (sample_tick) begin
                    samples++;
                    if (cyc - last_s != r + 1) gap_bad++;
                    last_s = cyc;
                    if (vote_tick) begin
                        votes++;
                        if (ratio == 16 && (sample_idx < 4'd7 || sample_idx > 4'd9)) vote_bad++;
                        if (ratio == 8 && (sample_idx < 4'd3 || sample_idx > 4'd5)) vote_bad++;
                        if (bit_tick) vote_bad++;
                    end
                end
            end while (!bit_tick && cyc < 600);
            chk(gap_bad == 0, "R2", "sample gap mismatches", gap_bad, 0);
            chk(cyc == ratio * (r + 1), req, "bit length in clocks", cyc, ratio * (r + 1));
            chk(samples == ratio, req, "samples per bit", samples, ratio);
            chk(votes == 3, "R6", "vote ticks per bit", votes, 3);
            chk(vote_bad == 0, "R6", "misplaced vote ticks", vote_bad, 0);
        end

        // ---- R1: disabled port stays quiet ----
        dbl_speed = 1'b0; sync_mode = 1'b0;
        write_reload(12'd0);
        @(negedge clk);
        port_en = 1'b0;
        @(negedge clk);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (sample_tick || bit_tick || vote_tick || sample_idx != 4'd0) seen++;
            end
            chk(seen == 0, "R1", "activity while disabled", seen, 0);
        end

        // ---- R8: first ticks after enable (R=2, 8-tick mode) ----
        dbl_speed  = 1'b1;
        reload_val = 12'd2;
        @(negedge clk);
        @(negedge clk);
        port_en = 1'b1;
        begin
            int first_s, first_b, first_idx;
            first_s = -1; first_b = -1; first_idx = -1;
            for (int i = 1; i <= 40; i++) begin
                @(negedge clk);
                if (sample_tick && first_s < 0) begin
                    first_s = i;
                    first_idx = int'(sample_idx);
                end
                if (bit_tick && first_b < 0) first_b = i;
            end
            chk(first_s == 2, "R8", "first sample tick cycle", first_s, 2);
            chk(first_idx == 0, "R8", "first sample index", first_idx, 0);
            chk(first_b == 23, "R8", "first bit tick cycle", first_b, 23);
        end

        // ---- R7: reload write mid-period restarts divider ----
        dbl_speed = 1'b0;
        write_reload(12'd9);
        repeat (4) @(negedge clk);
        reload_val = 12'd4;
        reload_wr  = 1'b1;
        begin
            int first_s, second_s;
            first_s = -1; second_s = -1;
            #1;
            chk(!sample_tick, "R7", "tick during write cycle", sample_tick, 0);
            for (int i = 1; i <= 14; i++) begin
                @(negedge clk);
                if (sample_tick) begin
                    if (first_s < 0) first_s = i;
                    else if (second_s < 0) second_s = i;
                end
                reload_wr = 1'b0;
            end
            chk(first_s == 5, "R7", "first tick after write", first_s, 5);
            chk(second_s == 10, "R2", "period after write", second_s, 10);
        end

        // ---- R1: synchronous reset clears index mid-bit ----
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sample_idx == 4'd0 && !sample_tick, "R1", "index after reset", sample_idx, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule